// File: doc/BRIEF.md
# Dual-Bus Serial Register Access Slave

This block lets an external controller read and write a byte-addressed register map over either a two-wire I2C bus or a four-wire SPI bus. A static strap input picks the bus. Both bus front ends share one internal register-bus port. That port issues single-cycle write strobes and read strobes, and carries an 8-bit address and 8-bit write data. Read data returns combinationally on the same cycle as the read strobe.

Every bus input passes through a two-flop synchroniser. The block then samples it with the system clock, which must run at least eight times faster than the bus clock. In I2C mode the block decodes start, repeated start and stop. It matches a fixed 7-bit device address and acknowledges the bytes it receives. It serves writes as a register address followed by data, and serves reads after a repeated start. Open-drain driving is modelled as an output enable, which pulls the line low when set.

In SPI mode, bit 7 of the first byte after chip select sets the direction of the transfer. The register address used is that byte with bit 7 forced to 1. In both modes the register pointer advances by one after each data byte of a continuing transfer.

Top module: `srs_serial_slave`

## Requirements
- R1: `if_sel` = 1 selects I2C and `if_sel` = 0 selects SPI. The bus that is not selected never drives its output enable and never causes a register access.
- R2: In I2C mode, the slave acknowledges an address byte only when its upper seven bits are 76h (write byte ECh, read byte EDh, bit 0 = 1 means read). Any other address gets no acknowledge, and the block makes no register access until the next start.
- R3: In an I2C write, the byte after the address is the register pointer. Each later data byte is written at the pointer, and the pointer then steps by one, wrapping from FFh to 00h.
- R4: After a repeated start with EDh, the slave returns data from the pointer, MSB first. Each master ACK advances the pointer and fetches the next byte. After a master NACK the slave releases SDA for the rest of the transfer.
- R5: In I2C mode, the slave pulls SDA low during the acknowledge bit of every byte it accepts (a matching address, the register byte and each data byte).
- R6: A stop returns the I2C side to idle. A start at any point restarts at the device-address byte and keeps the pointer.
- R7: In SPI mode, an address byte with bit 7 = 0 starts a write. Each following byte goes to the address with bit 7 forced to 1. After each byte the low seven bits step by one and bit 7 stays 1.
- R8: In SPI mode, an address byte with bit 7 = 1 starts a read from that address. Each read byte is presented MSB first, changing after a falling SCLK and sampled by the master on the rising edge. Each completed byte advances the address as in R7.
- R9: The MISO output enable stays low during the address byte, throughout writes and while chip select is high.
- R10: Raising chip select aborts a transfer. A partial byte is discarded, and the next selection starts with a new address byte.
- R11: After reset, both output enables are low, no register strobe is active, and no read and write strobe ever fire in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the bus clock |
| rst_n | input | 1 | Active-low reset of both engines and the pointer |
| if_sel | input | 1 | Bus strap: 1 = I2C, 0 = SPI |
| scl_i | input | 1 | I2C clock line |
| sda_i | input | 1 | I2C data line as seen on the bus |
| sda_oe | output | 1 | Pull SDA low when 1 |
| cs_n_i | input | 1 | SPI chip select, active low |
| sclk_i | input | 1 | SPI clock |
| mosi_i | input | 1 | SPI data from master |
| miso_o | output | 1 | SPI data to master |
| miso_oe | output | 1 | MISO driver enable (high impedance when 0) |
| reg_wr | output | 1 | Register write strobe |
| reg_rd | output | 1 | Register read strobe |
| reg_addr | output | 8 | Register address (current pointer) |
| reg_wdata | output | 8 | Register write data |
| reg_rdata | input | 8 | Register read data, valid with reg_rd |

## Verification
The bench builds the block with its default parameters: device address 76h and two synchroniser stages. With these, every one of the 127 non-matching 7-bit device addresses can be swept and shown to draw neither an acknowledge nor an access. The bench also sweeps a 16-byte block written and read back through pointer auto-increment, and covers the pointer wrap at FFh for I2C and at 7Fh-to-80h for SPI. The bus half period is six system clocks, so every sampling point of the bench falls clear of the three-cycle synchroniser and edge-detect latency.

// File: rtl/srs_pkg.sv
package srs_pkg;
  localparam int unsigned REG_AW = 8;
  localparam int unsigned REG_DW = 8;

  typedef enum logic [2:0] {
    I_IDLE, I_DEV, I_REG, I_WDATA, I_RDATA, I_SKIP
  } i2c_st_e;

  typedef struct packed {
    logic              wr;
    logic              rd;
    logic [REG_AW-1:0] addr;
    logic [REG_DW-1:0] wdata;
  } regbus_t;

  // Pointer step: plain wrap, or keep the top bit set and wrap the rest.
  function automatic logic [REG_AW-1:0] ptr_step(input logic [REG_AW-1:0] p,
                                                 input logic keep_msb);
    ptr_step = keep_msb ? {1'b1, p[REG_AW-2:0] + {{(REG_AW-2){1'b0}}, 1'b1}}
                        : p + {{(REG_AW-1){1'b0}}, 1'b1};
  endfunction
endpackage

// File: rtl/srs_sync.sv
module srs_sync #(
  parameter int unsigned W      = 5,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[s] <= '1;
      else if (s == 0) chain[s] <= d;
      else chain[s] <= chain[(s == 0) ? 0 : s-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/srs_i2c_eng.sv
module srs_i2c_eng import srs_pkg::*; #(
  parameter logic [6:0] DEV_ADDR = 7'h76
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              scl,
  input  logic              sda,
  input  logic [REG_DW-1:0] rdata,
  output regbus_t           bus,
  output logic              sda_oe,
  output logic              start_evt,
  output logic              stop_evt,
  output logic              skipping
);
  logic scl_q, sda_q;
  i2c_st_e st;
  logic [3:0] cnt;
  logic ack_ph, mack, wr_p, rd_p;
  logic [REG_DW-1:0] rx, tx, wdat;
  logic [REG_AW-1:0] ptr;

  wire scl_rise = scl & ~scl_q;
  wire scl_fall = ~scl & scl_q;
  assign start_evt = en & scl & scl_q & sda_q & ~sda;
  assign stop_evt  = en & scl & scl_q & ~sda_q & sda;
  assign skipping  = (st == I_SKIP);
  wire active = (st != I_IDLE) && (st != I_SKIP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1; sda_q <= 1'b1;
      st <= I_IDLE; cnt <= '0; ack_ph <= 1'b0; mack <= 1'b1;
      wr_p <= 1'b0; rd_p <= 1'b0; rx <= '0; tx <= '0; wdat <= '0;
      ptr <= '0; sda_oe <= 1'b0;
    end else begin
      scl_q <= scl; sda_q <= sda;
      wr_p <= 1'b0; rd_p <= 1'b0;
      if (wr_p) ptr <= ptr_step(ptr, 1'b0);
      if (rd_p) begin tx <= rdata; sda_oe <= ~rdata[REG_DW-1]; end
      if (!en || stop_evt) begin
        st <= I_IDLE; cnt <= '0; ack_ph <= 1'b0; sda_oe <= 1'b0;
      end else if (start_evt) begin
        st <= I_DEV; cnt <= '0; ack_ph <= 1'b0; sda_oe <= 1'b0;
      end else if (active) begin
        if (scl_rise) begin
          if (ack_ph) mack <= sda;
          else begin rx <= {rx[REG_DW-2:0], sda}; cnt <= cnt + 4'd1; end
        end else if (scl_fall) begin
          if (ack_ph) begin
            // end of the acknowledge bit
            ack_ph <= 1'b0; cnt <= '0; sda_oe <= 1'b0;
            if (st == I_DEV) begin
              st   <= rx[0] ? I_RDATA : I_REG;
              rd_p <= rx[0];
            end else if (st == I_RDATA) begin
              if (!mack) begin ptr <= ptr_step(ptr, 1'b0); rd_p <= 1'b1; end
              else st <= I_SKIP;
            end
          end else if (cnt == 4'd8) begin
            // eight bits received or sent: enter the acknowledge bit
            unique case (st)
              I_DEV: begin
                if (rx[7:1] == DEV_ADDR) begin ack_ph <= 1'b1; sda_oe <= 1'b1; end
                else begin st <= I_SKIP; cnt <= '0; end
              end
              I_REG:   begin ptr <= rx; st <= I_WDATA; ack_ph <= 1'b1; sda_oe <= 1'b1; end
              I_WDATA: begin wdat <= rx; wr_p <= 1'b1; ack_ph <= 1'b1; sda_oe <= 1'b1; end
              default: begin ack_ph <= 1'b1; sda_oe <= 1'b0; end
            endcase
          end else if (st == I_RDATA && cnt != 4'd0) begin
            sda_oe <= ~tx[3'd7 - cnt[2:0]];
          end
        end
      end
    end
  end

  assign bus = '{wr: wr_p, rd: rd_p, addr: ptr, wdata: wdat};
endmodule

// File: rtl/srs_spi_eng.sv
module srs_spi_eng import srs_pkg::*; (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              cs_n,
  input  logic              sclk,
  input  logic              mosi,
  input  logic [REG_DW-1:0] rdata,
  output regbus_t           bus,
  output logic              miso,
  output logic              miso_oe
);
  logic sclk_q, in_data, is_rd, wr_p, rd_p;
  logic [2:0] cnt;
  logic [REG_DW-1:0] rx, tx, wdat;
  logic [REG_AW-1:0] ptr;

  wire sclk_rise = sclk & ~sclk_q;
  wire sclk_fall = ~sclk & sclk_q;
  wire [REG_DW-1:0] byte_now = {rx[REG_DW-2:0], mosi};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= 1'b0; in_data <= 1'b0; is_rd <= 1'b0; wr_p <= 1'b0; rd_p <= 1'b0;
      cnt <= '0; rx <= '0; tx <= '0; wdat <= '0; ptr <= '0;
      miso <= 1'b0; miso_oe <= 1'b0;
    end else begin
      sclk_q <= sclk;
      wr_p <= 1'b0; rd_p <= 1'b0;
      if (wr_p) ptr <= ptr_step(ptr, 1'b1);
      if (rd_p) tx <= rdata;
      if (!en || cs_n) begin
        cnt <= '0; in_data <= 1'b0; is_rd <= 1'b0; miso_oe <= 1'b0;
      end else if (sclk_rise) begin
        rx  <= byte_now;
        cnt <= cnt + 3'd1;
        if (cnt == 3'd7) begin
          if (!in_data) begin
            in_data <= 1'b1;
            is_rd   <= byte_now[7];
            ptr     <= {1'b1, byte_now[6:0]};
            rd_p    <= byte_now[7];
          end else if (is_rd) begin
            ptr <= ptr_step(ptr, 1'b1); rd_p <= 1'b1;
          end else begin
            wdat <= byte_now; wr_p <= 1'b1;
          end
        end
      end else if (sclk_fall && in_data && is_rd) begin
        miso    <= tx[3'd7 - cnt];
        miso_oe <= 1'b1;
      end
    end
  end

  assign bus = '{wr: wr_p, rd: rd_p, addr: ptr, wdata: wdat};
endmodule

// File: rtl/srs_serial_slave.sv
module srs_serial_slave import srs_pkg::*; #(
  parameter logic [6:0]  DEV_ADDR    = 7'h76,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              if_sel,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  input  logic              cs_n_i,
  input  logic              sclk_i,
  input  logic              mosi_i,
  output logic              miso_o,
  output logic              miso_oe,
  output logic              reg_wr,
  output logic              reg_rd,
  output logic [REG_AW-1:0] reg_addr,
  output logic [REG_DW-1:0] reg_wdata,
  input  logic [REG_DW-1:0] reg_rdata
);
  localparam int unsigned NSYNC = 5;

  logic [NSYNC-1:0] raw_in, syn;
  logic scl_s, sda_s, cs_s, sclk_s, mosi_s;
  logic i2c_start, i2c_stop, i2c_skip;
  regbus_t ib, sb, sel;

  assign raw_in = {scl_i, sda_i, cs_n_i, sclk_i, mosi_i};
  assign {scl_s, sda_s, cs_s, sclk_s, mosi_s} = syn;

  srs_sync #(.W(NSYNC), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw_in), .q(syn));

  srs_i2c_eng #(.DEV_ADDR(DEV_ADDR)) u_i2c (
    .clk(clk), .rst_n(rst_n), .en(if_sel), .scl(scl_s), .sda(sda_s),
    .rdata(reg_rdata), .bus(ib), .sda_oe(sda_oe),
    .start_evt(i2c_start), .stop_evt(i2c_stop), .skipping(i2c_skip));

  srs_spi_eng u_spi (
    .clk(clk), .rst_n(rst_n), .en(~if_sel), .cs_n(cs_s), .sclk(sclk_s),
    .mosi(mosi_s), .rdata(reg_rdata), .bus(sb), .miso(miso_o), .miso_oe(miso_oe));

  assign sel       = if_sel ? ib : sb;
  assign reg_wr    = sel.wr;
  assign reg_rd    = sel.rd;
  assign reg_addr  = sel.addr;
  assign reg_wdata = sel.wdata;
endmodule

// File: rtl/srs_serial_slave_chk.sv
module srs_serial_slave_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       if_sel,
  input logic       sda_oe,
  input logic       miso_oe,
  input logic       reg_wr,
  input logic       reg_rd,
  input logic [7:0] reg_addr,
  input logic       cs_s,
  input logic       i2c_start,
  input logic       i2c_stop,
  input logic       i2c_skip
);
  a_r11_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr && reg_rd));
  a_r1_sda_quiet_in_spi: assert property (@(posedge clk) disable iff (!rst_n)
    !if_sel |=> !sda_oe);
  a_r9_miso_off_deselected: assert property (@(posedge clk) disable iff (!rst_n)
    cs_s |=> !miso_oe);
  a_r2_skip_no_access: assert property (@(posedge clk) disable iff (!rst_n)
    (if_sel && i2c_skip) |-> (!reg_wr && !reg_rd));
  a_r6_stop_releases: assert property (@(posedge clk) disable iff (!rst_n)
    i2c_stop |=> !sda_oe);
  a_r6_start_releases: assert property (@(posedge clk) disable iff (!rst_n)
    i2c_start |=> !sda_oe);
  a_r7_spi_write_high: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && !if_sel) |-> reg_addr[7]);
  a_r3_i2c_step: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && if_sel) |=> (reg_addr == $past(reg_addr) + 8'd1));
endmodule

bind srs_serial_slave srs_serial_slave_chk u_chk (
  .clk(clk), .rst_n(rst_n), .if_sel(if_sel), .sda_oe(sda_oe), .miso_oe(miso_oe),
  .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr), .cs_s(cs_s),
  .i2c_start(i2c_start), .i2c_stop(i2c_stop), .i2c_skip(i2c_skip));

// File: tb/srs_serial_slave_bench.sv
`timescale 1ns/1ps
module srs_serial_slave_bench;
  localparam int T = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic if_sel = 1'b1;
  logic scl = 1'b1, m_sda = 1'b1;
  logic cs_n = 1'b1, sclk = 1'b0, mosi = 1'b0;
  logic sda_oe, miso_o, miso_oe, reg_wr, reg_rd;
  logic [7:0] reg_addr, reg_wdata, reg_rdata;
  logic [7:0] mem [256];
  logic [7:0] expv [256];
  int vecs = 0, errs = 0;
  int n_wr = 0, n_rd = 0, n_sda = 0, n_miso = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  wire sda_line  = m_sda & ~sda_oe;
  wire miso_line = miso_oe ? miso_o : 1'b1;

  srs_serial_slave u_srs_serial_slave (
    .clk(clk), .rst_n(rst_n), .if_sel(if_sel), .scl_i(scl), .sda_i(sda_line),
    .sda_oe(sda_oe), .cs_n_i(cs_n), .sclk_i(sclk), .mosi_i(mosi), .miso_o(miso_o),
    .miso_oe(miso_oe), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata));

  function automatic logic [7:0] init_val(input int i);
    init_val = 8'((i * 29 + 11) & 8'hFF);
  endfunction

  assign reg_rdata = mem[reg_addr];

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) mem[i] <= init_val(i);
    end else begin
      if (reg_wr) mem[reg_addr] <= reg_wdata;
      n_wr   <= n_wr + int'(reg_wr);
      n_rd   <= n_rd + int'(reg_rd);
      n_sda  <= n_sda + int'(sda_oe);
      n_miso <= n_miso + int'(miso_oe);
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    vecs++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // ---- I2C master ----
  task automatic i_start();
    m_sda = 1'b1; tick(T); scl = 1'b1; tick(T); m_sda = 1'b0; tick(T); scl = 1'b0; tick(T);
  endtask
  task automatic i_stop();
    m_sda = 1'b0; tick(T); scl = 1'b1; tick(T); m_sda = 1'b1; tick(T);
  endtask
  task automatic i_wbyte(input logic [7:0] b, output logic nack);
    for (int k = 7; k >= 0; k--) begin
      m_sda = b[k]; tick(T); scl = 1'b1; tick(T); scl = 1'b0; tick(T);
    end
    m_sda = 1'b1; tick(T); scl = 1'b1; tick(T/2); nack = sda_line; tick(T/2);
    scl = 1'b0; tick(T);
  endtask
  task automatic i_rbyte(input logic nack_in, output logic [7:0] b);
    m_sda = 1'b1;
    for (int k = 7; k >= 0; k--) begin
      tick(T); scl = 1'b1; tick(T/2); b[k] = sda_line; tick(T/2); scl = 1'b0;
    end
    tick(T); m_sda = nack_in; tick(T); scl = 1'b1; tick(T); scl = 1'b0; tick(T);
    m_sda = 1'b1;
  endtask

  // ---- SPI master ----
  task automatic s_byte(input logic [7:0] o, output logic [7:0] r);
    for (int k = 7; k >= 0; k--) begin
      mosi = o[k]; tick(T); r[k] = miso_line; sclk = 1'b1; tick(T); sclk = 0;
    end
  endtask

  initial begin
    logic nk;
    logic [7:0] rb;
    int w0, r0, s0, m0;
    for (int i = 0; i < 256; i++) expv[i] = init_val(i);
    tick(4);
    // R11: reset state
    chk("R11 sda_oe at reset", int'(sda_oe), 0);
    chk("R11 miso_oe at reset", int'(miso_oe), 0);
    chk("R11 strobes at reset", int'(reg_wr | reg_rd), 0);
    rst_n = 1'b1; tick(4);

    // R3/R5: I2C write of three bytes at F0h
    i_start(); i_wbyte(8'hEC, nk); chk("R5 ack of ECh", int'(nk), 0);
    i_wbyte(8'hF0, nk); chk("R5 ack of register byte", int'(nk), 0);
    for (int j = 0; j < 3; j++) begin
      i_wbyte(8'hA0 + 8'(j), nk); chk("R5 ack of data byte", int'(nk), 0);
      expv[8'hF0 + j] = 8'hA0 + 8'(j);
    end
    i_stop(); tick(T);
    for (int j = 0; j < 3; j++) chk("R3 write sequence", int'(mem[8'hF0 + j]), int'(expv[8'hF0 + j]));
    // R3: pointer wraps FFh -> 00h
    i_start(); i_wbyte(8'hEC, nk); i_wbyte(8'hFF, nk);
    i_wbyte(8'h11, nk); i_wbyte(8'h22, nk); i_stop(); tick(T);
    expv[8'hFF] = 8'h11; expv[8'h00] = 8'h22;
    chk("R3 wrap FFh", int'(mem[8'hFF]), 8'h11);
    chk("R3 wrap 00h", int'(mem[8'h00]), 8'h22);

    // R4: read back F0h..F2h through repeated start
    i_start(); i_wbyte(8'hEC, nk); i_wbyte(8'hF0, nk);
    i_start(); i_wbyte(8'hED, nk); chk("R2 ack of EDh", int'(nk), 0);
    for (int j = 0; j < 3; j++) begin
      i_rbyte(j == 2, rb); chk("R4 read data", int'(rb), int'(expv[8'hF0 + j]));
    end
    chk("R4 SDA released after NACK", int'(sda_oe), 0);
    i_stop(); tick(T);

    // R3/R4: 16-byte block sweep at C0h
    i_start(); i_wbyte(8'hEC, nk); i_wbyte(8'hC0, nk);
    for (int j = 0; j < 16; j++) begin
      i_wbyte(8'((j * 37 + 5) & 8'hFF), nk); expv[8'hC0 + j] = 8'((j * 37 + 5) & 8'hFF);
    end
    i_start(); i_wbyte(8'hEC, nk); i_wbyte(8'hC0, nk); i_start(); i_wbyte(8'hED, nk);
    for (int j = 0; j < 16; j++) begin
      i_rbyte(j == 15, rb); chk("R4 block read", int'(rb), int'(expv[8'hC0 + j]));
    end
    i_stop(); tick(T);

    // R6: start in the middle of a write restarts at device address
    i_start(); i_wbyte(8'hEC, nk); i_wbyte(8'h10, nk); i_wbyte(8'h3C, nk);
    i_start(); i_wbyte(8'hEC, nk); chk("R6 ack after restart", int'(nk), 0);
    i_wbyte(8'h20, nk); i_wbyte(8'h4D, nk); i_stop(); tick(T);
    chk("R6 first write", int'(mem[8'h10]), 8'h3C);
    chk("R6 second write", int'(mem[8'h20]), 8'h4D);
    chk("R6 no stray write", int'(mem[8'h11]), int'(expv[8'h11]));
    chk("R6 idle after stop", int'(sda_oe), 0);

    // R2: sweep of every non-matching device address
    w0 = n_wr; r0 = n_rd;
    for (int a = 0; a < 128; a++) begin
      if (a == 7'h76) continue;
      i_start(); i_wbyte({7'(a), 1'b0}, nk);
      chk("R2 no ack for foreign address", int'(nk), 1);
      i_wbyte(8'h33, nk); i_stop();
    end
    tick(T);
    chk("R2 no access after foreign address", n_wr + n_rd - w0 - r0, 0);

    // R1: SPI traffic while I2C is selected
    w0 = n_wr; m0 = n_miso;
    cs_n = 1'b0; tick(T); s_byte(8'h05, rb); s_byte(8'h99, rb); cs_n = 1'b1; tick(2*T);
    chk("R1 SPI ignored in I2C mode (writes)", n_wr - w0, 0);
    chk("R1 SPI ignored in I2C mode (miso_oe)", n_miso - m0, 0);

    // switch to SPI
    if_sel = 1'b0; tick(4);
    w0 = n_wr; s0 = n_sda;
    i_start(); i_wbyte(8'hEC, nk); chk("R1 no I2C ack in SPI mode", int'(nk), 1);
    i_wbyte(8'h40, nk); i_wbyte(8'h77, nk); i_stop(); tick(T);
    chk("R1 I2C ignored in SPI mode (writes)", n_wr - w0, 0);
    chk("R1 I2C ignored in SPI mode (sda_oe)", n_sda - s0, 0);

    // R7/R9: SPI write at 05h -> 85h, 86h
    m0 = n_miso;
    cs_n = 1'b0; tick(T); s_byte(8'h05, rb); s_byte(8'h5E, rb); s_byte(8'h6F, rb);
    tick(T); cs_n = 1'b1; tick(2*T);
    expv[8'h85] = 8'h5E; expv[8'h86] = 8'h6F;
    chk("R7 write forced bit 7", int'(mem[8'h85]), 8'h5E);
    chk("R7 write increment", int'(mem[8'h86]), 8'h6F);
    chk("R7 bit-7-clear address untouched", int'(mem[8'h05]), int'(expv[8'h05]));
    chk("R9 miso_oe low in write", n_miso - m0, 0);
    // R7: wrap 7Fh -> FFh then 80h
    cs_n = 1'b0; tick(T); s_byte(8'h7F, rb); s_byte(8'hC1, rb); s_byte(8'hC2, rb);
    tick(T); cs_n = 1'b1; tick(2*T);
    expv[8'hFF] = 8'hC1; expv[8'h80] = 8'hC2;
    chk("R7 wrap FFh", int'(mem[8'hFF]), 8'hC1);
    chk("R7 wrap 80h", int'(mem[8'h80]), 8'hC2);

    // R8/R9: SPI read from 85h
    m0 = n_miso;
    cs_n = 1'b0; tick(T); s_byte(8'h85, rb);
    chk("R9 miso_oe low in address byte", n_miso - m0, 0);
    for (int j = 0; j < 3; j++) begin
      s_byte(8'h00, rb); chk("R8 read data", int'(rb), int'(expv[8'h85 + j]));
    end
    tick(T); cs_n = 1'b1; tick(2*T);
    chk("R9 miso_oe low when deselected", int'(miso_oe), 0);

    // R10: abort mid-byte then a fresh selection
    cs_n = 1'b0; tick(T); s_byte(8'h10, rb);
    for (int k = 0; k < 4; k++) begin
      mosi = 1'b1; tick(T); sclk = 1'b1; tick(T); sclk = 1'b0;
    end
    tick(T); cs_n = 1'b1; tick(2*T);
    cs_n = 1'b0; tick(T); s_byte(8'h20, rb); s_byte(8'h5A, rb); tick(T); cs_n = 1'b1; tick(2*T);
    chk("R10 partial byte discarded", int'(mem[8'h90]), int'(expv[8'h90]));
    chk("R10 new transfer after abort", int'(mem[8'hA0]), 8'h5A);

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errs++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end
endmodule